// File: doc/BRIEF.md
# Packed-Register Video Timing Generator

This block produces the raster timing for a display transmitter. It runs on the pixel clock. Two counters walk across each line and down each frame. From their positions the block decodes data-enable, horizontal sync and vertical sync, and it applies a programmable polarity to each sync output. The geometry comes from a small bank of 32-bit registers loaded through a simple write port. Each register holds a vertical quantity in its upper half and a horizontal quantity in its lower half. Every field is stored as its real count minus one.

Along a line the order is active pixels, then front porch, then sync, then whatever the back-porch field has left after the sync pulse. The back-porch field is measured from sync start, so it includes the sync width. The same rule applies to lines within a frame. A pixel-repetition mode expects the horizontal values to be programmed already doubled. In that mode the block also reports the source pixel index, which is the line position halved. Register writes land in a live copy. The timing logic uses a shadow copy that is reloaded only when a frame ends, so a frame is never torn.

All outputs are registered. They appear one pixel clock after the counter state they describe, and all of them are aligned with one another.

Top module: `packed_vtg_top`

## Requirements
- R1: A write with `wr_en` high loads `wr_data` into the register chosen by `wr_addr`: 0 control, 1 active size, 2 back porch, 3 front porch, 4 sync width, 5 polarity. In registers 1 to 4, bits [31:16] hold the vertical count minus one and bits [15:0] hold the horizontal count minus one.
- R2: The line position runs from 0 to HA+HF+HB-1 and then wraps to 0. The line number advances by one at each wrap and itself wraps after VA+VF+VB-1. Here HA, HF and HB are the real active, front-porch and back-porch counts.
- R3: `de_o` is high exactly when video is enabled, the line position is below HA and the line number is below VA.
- R4: Horizontal sync is asserted for positions from HA+HF up to, but not including, HA+HF+HW. Vertical sync is asserted for whole lines from VA+VF up to, but not including, VA+VF+VW.
- R5: In the polarity register, bit 1 sets vertical sync and bit 0 sets horizontal sync. A value of 1 means active-high and 0 means active-low.
- R6: With video enable (control bit 31) at 0, `de_o` stays low and both sync outputs stay at their inactive level for the whole frame.
- R7: A register write does not change the frame in progress. The new values apply from the next frame start. A write in the same cycle as a frame boundary applies one frame later.
- R8: With repetition (control bit 0) set, `src_px_o` equals the line position divided by two. Otherwise it equals the line position. Horizontal fields are used exactly as programmed.
- R9: Control bit 30 and control bit 4 appear on `hdmi_mode_o` and `interlace_o`. They change only at a frame start.
- R10: After reset every register is zero, which gives a 3 x 3 frame with video disabled. Both sync outputs sit high (active-low, inactive), and the positions step (0,0), (1,0), (2,0), (0,1) from the first clock after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select |
| wr_data | input | 32 | Register write data |
| de_o | output | 1 | Data enable |
| hsync_o | output | 1 | Horizontal sync, polarity applied |
| vsync_o | output | 1 | Vertical sync, polarity applied |
| h_pos_o | output | 18 | Position within the line |
| v_pos_o | output | 18 | Line number within the frame |
| src_px_o | output | 18 | Source pixel index (halved when repeating) |
| hdmi_mode_o | output | 1 | Latched mode flag |
| interlace_o | output | 1 | Latched interlace flag |

## Verification
Two events can meet in one clock: a register write and the frame-boundary reload of the shadow copy. The bench watches the reported positions until it sees the second-to-last pixel of a frame. It then drives a write of the active-size register, so the write is sampled on the same edge as the reload. The bench requires that the following frame still follows the old geometry on every pixel and that the frame after it follows the new one. A separate test writes in the middle of a frame and checks that the rest of that frame is unchanged.

// File: rtl/vtg_pkg.sv
// Package: shared widths, register addresses and the configuration record
// for the packed-register video timing generator.
package vtg_pkg;
    localparam int FIELD_W = 16;            // one half of a packed register
    localparam int CNT_W   = FIELD_W + 2;   // holds the sum of three fields
    localparam int ADDR_W  = 3;
    localparam int DATA_W  = 2 * FIELD_W;

    localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] A_ACT  = 3'd1;
    localparam logic [ADDR_W-1:0] A_BP   = 3'd2;
    localparam logic [ADDR_W-1:0] A_FP   = 3'd3;
    localparam logic [ADDR_W-1:0] A_SW   = 3'd4;
    localparam logic [ADDR_W-1:0] A_POL  = 3'd5;

    // One axis worth of timing, every field stored as count minus one.
    typedef struct packed {
        logic [FIELD_W-1:0] act;
        logic [FIELD_W-1:0] fp;
        logic [FIELD_W-1:0] bp;   // measured from sync start
        logic [FIELD_W-1:0] sw;
    } axis_cfg_t;

    typedef struct packed {
        axis_cfg_t h;
        axis_cfg_t v;
        logic      pol_v;
        logic      pol_h;
        logic      en;
        logic      hdmi;
        logic      ilace;
        logic      rep;
    } vtg_cfg_t;
endpackage

// File: rtl/vtg_regbank.sv
// Register bank: the write port fills a live copy, and the shadow copy that
// drives the timing logic is reloaded only on frame_start.
// Assumes frame_start is a single-cycle pulse on the last pixel of a frame.
module vtg_regbank
    import vtg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              frame_start,
    output vtg_cfg_t          cfg_q
);
    vtg_cfg_t live_q;

    // Decode the write port into the live copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_q <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                A_CTRL: begin
                    live_q.en    <= wr_data[31];
                    live_q.hdmi  <= wr_data[30];
                    live_q.ilace <= wr_data[4];
                    live_q.rep   <= wr_data[0];
                end
                A_ACT: begin
                    live_q.v.act <= wr_data[DATA_W-1:FIELD_W];
                    live_q.h.act <= wr_data[FIELD_W-1:0];
                end
                A_BP: begin
                    live_q.v.bp <= wr_data[DATA_W-1:FIELD_W];
                    live_q.h.bp <= wr_data[FIELD_W-1:0];
                end
                A_FP: begin
                    live_q.v.fp <= wr_data[DATA_W-1:FIELD_W];
                    live_q.h.fp <= wr_data[FIELD_W-1:0];
                end
                A_SW: begin
                    live_q.v.sw <= wr_data[DATA_W-1:FIELD_W];
                    live_q.h.sw <= wr_data[FIELD_W-1:0];
                end
                A_POL: begin
                    live_q.pol_v <= wr_data[1];
                    live_q.pol_h <= wr_data[0];
                end
                default: ;
            endcase
        end
    end

    // Copy live to shadow at the frame boundary only.
    always_ff @(posedge clk) begin
        if (!rst_n)           cfg_q <= '0;
        else if (frame_start) cfg_q <= live_q;
    end

    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(cfg_q)); // R7
endmodule

// File: rtl/vtg_counter.sv
// Raster counters: the line position wraps after active + front porch +
// back-porch field, and the line number advances on each wrap.
// Assumes cfg is stable except on the cycle after frame_start.
module vtg_counter
    import vtg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  vtg_cfg_t         cfg,
    output logic [CNT_W-1:0] h_cnt,
    output logic [CNT_W-1:0] v_cnt,
    output logic             frame_start
);
    logic [CNT_W-1:0] h_total, v_total;
    logic             h_end, v_end;

    // Totals from minus-one fields: three fields, so add three.
    assign h_total = CNT_W'(cfg.h.act) + CNT_W'(cfg.h.fp) + CNT_W'(cfg.h.bp) + CNT_W'(3);
    assign v_total = CNT_W'(cfg.v.act) + CNT_W'(cfg.v.fp) + CNT_W'(cfg.v.bp) + CNT_W'(3);
    assign h_end   = (h_cnt == h_total - CNT_W'(1));
    assign v_end   = (v_cnt == v_total - CNT_W'(1));
    assign frame_start = h_end && v_end;

    // Line position counter.
    always_ff @(posedge clk) begin
        if (!rst_n)     h_cnt <= '0;
        else if (h_end) h_cnt <= '0;
        else            h_cnt <= h_cnt + CNT_W'(1);
    end

    // Line number counter, stepped at each line wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)          v_cnt <= '0;
        else if (frame_start) v_cnt <= '0;
        else if (h_end)      v_cnt <= v_cnt + CNT_W'(1);
    end

    AST_H_BELOW_TOTAL: assert property (@(posedge clk) disable iff (!rst_n)
        h_cnt < h_total); // R2
    AST_H_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !h_end |=> h_cnt == $past(h_cnt) + CNT_W'(1)); // R2
    AST_V_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !h_end |=> $stable(v_cnt)); // R2
endmodule

// File: rtl/vtg_decode.sv
// Region decoder: turns counter positions into data enable and sync with
// polarity and enable gating, registering every output in one stage.
// Assumes counters and cfg come from the same clock domain.
module vtg_decode
    import vtg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  vtg_cfg_t         cfg,
    input  logic [CNT_W-1:0] h_cnt,
    input  logic [CNT_W-1:0] v_cnt,
    output logic             de_o,
    output logic             hsync_o,
    output logic             vsync_o,
    output logic [CNT_W-1:0] h_pos_o,
    output logic [CNT_W-1:0] v_pos_o,
    output logic [CNT_W-1:0] src_px_o,
    output logic             hdmi_mode_o,
    output logic             interlace_o
);
    logic [CNT_W-1:0] h_act_n, v_act_n, hs_beg, vs_beg, hs_fin, vs_fin;
    logic             in_act, hs_act, vs_act;

    // Window edges in real counts.
    assign h_act_n = CNT_W'(cfg.h.act) + CNT_W'(1);
    assign v_act_n = CNT_W'(cfg.v.act) + CNT_W'(1);
    assign hs_beg  = h_act_n + CNT_W'(cfg.h.fp) + CNT_W'(1);
    assign vs_beg  = v_act_n + CNT_W'(cfg.v.fp) + CNT_W'(1);
    assign hs_fin  = hs_beg + CNT_W'(cfg.h.sw) + CNT_W'(1);
    assign vs_fin  = vs_beg + CNT_W'(cfg.v.sw) + CNT_W'(1);

    // Region membership for the current counter position.
    assign in_act = (h_cnt < h_act_n) && (v_cnt < v_act_n);
    assign hs_act = (h_cnt >= hs_beg) && (h_cnt < hs_fin);
    assign vs_act = (v_cnt >= vs_beg) && (v_cnt < vs_fin);

    // Output register stage with polarity and enable gating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            de_o        <= 1'b0;
            hsync_o     <= 1'b1;
            vsync_o     <= 1'b1;
            h_pos_o     <= '0;
            v_pos_o     <= '0;
            src_px_o    <= '0;
            hdmi_mode_o <= 1'b0;
            interlace_o <= 1'b0;
        end else begin
            de_o        <= cfg.en && in_act;
            hsync_o     <= (cfg.en && hs_act) ? cfg.pol_h : !cfg.pol_h;
            vsync_o     <= (cfg.en && vs_act) ? cfg.pol_v : !cfg.pol_v;
            h_pos_o     <= h_cnt;
            v_pos_o     <= v_cnt;
            src_px_o    <= cfg.rep ? (h_cnt >> 1) : h_cnt;
            hdmi_mode_o <= cfg.hdmi;
            interlace_o <= cfg.ilace;
        end
    end

    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.en |=> (!de_o && hsync_o == !$past(cfg.pol_h) && vsync_o == !$past(cfg.pol_v))); // R6
    AST_SRC_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        cfg.rep |=> src_px_o == (h_pos_o >> 1)); // R8
    AST_DE_NOT_IN_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        (de_o && hs_beg > h_act_n) |-> hsync_o == !$past(cfg.pol_h)); // R4
endmodule

// File: rtl/packed_vtg_top.sv
// Top of the video timing generator: register bank, raster counters and
// region decoder. Assumes one pixel clock and synchronous active-low reset.
module packed_vtg_top
    import vtg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              de_o,
    output logic              hsync_o,
    output logic              vsync_o,
    output logic [CNT_W-1:0]  h_pos_o,
    output logic [CNT_W-1:0]  v_pos_o,
    output logic [CNT_W-1:0]  src_px_o,
    output logic              hdmi_mode_o,
    output logic              interlace_o
);
    vtg_cfg_t         cfg;
    logic [CNT_W-1:0] h_cnt, v_cnt;
    logic             frame_start;

    vtg_regbank u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .frame_start(frame_start), .cfg_q(cfg)
    );

    vtg_counter u_cnt (
        .clk(clk), .rst_n(rst_n), .cfg(cfg),
        .h_cnt(h_cnt), .v_cnt(v_cnt), .frame_start(frame_start)
    );

    vtg_decode u_dec (
        .clk(clk), .rst_n(rst_n), .cfg(cfg), .h_cnt(h_cnt), .v_cnt(v_cnt),
        .de_o(de_o), .hsync_o(hsync_o), .vsync_o(vsync_o),
        .h_pos_o(h_pos_o), .v_pos_o(v_pos_o), .src_px_o(src_px_o),
        .hdmi_mode_o(hdmi_mode_o), .interlace_o(interlace_o)
    );
endmodule

// File: tb/packed_vtg_top_tb.sv
module packed_vtg_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        de_o, hsync_o, vsync_o, hdmi_mode_o, interlace_o;
    logic [17:0] h_pos_o, v_pos_o, src_px_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;   // 200 MHz

    packed_vtg_top dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .de_o(de_o), .hsync_o(hsync_o), .vsync_o(vsync_o),
        .h_pos_o(h_pos_o), .v_pos_o(v_pos_o), .src_px_o(src_px_o),
        .hdmi_mode_o(hdmi_mode_o), .interlace_o(interlace_o)
    );

    // Stimulus table: real counts per row.
    localparam int NROW = 5;
    localparam int T_HA [NROW] = '{8, 6, 8, 5, 1};
    localparam int T_HF [NROW] = '{2, 1, 2, 1, 1};
    localparam int T_HB [NROW] = '{6, 3, 4, 2, 1};
    localparam int T_HW [NROW] = '{3, 1, 2, 1, 1};
    localparam int T_VA [NROW] = '{4, 3, 2, 2, 1};
    localparam int T_VF [NROW] = '{1, 2, 1, 1, 1};
    localparam int T_VB [NROW] = '{3, 2, 2, 1, 1};
    localparam int T_VW [NROW] = '{2, 1, 2, 1, 1};
    localparam int T_PV [NROW] = '{1, 0, 0, 1, 1};
    localparam int T_PH [NROW] = '{1, 0, 1, 0, 1};
    localparam int T_EN [NROW] = '{1, 1, 1, 0, 1};
    localparam int T_RP [NROW] = '{0, 0, 1, 0, 0};
    localparam int T_HD [NROW] = '{0, 1, 0, 0, 1};
    localparam int T_IL [NROW] = '{0, 0, 1, 0, 0};

    int e_ha, e_hf, e_hb, e_hw, e_va, e_vf, e_vb, e_vw, e_pv, e_ph, e_en, e_rp, e_hd, e_il;

    function automatic logic [31:0] pk(int v, int h);
        return {16'(v - 1), 16'(h - 1)};
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Called at a negedge; drives one write, sampled on the next posedge.
    task automatic wr_reg(logic [2:0] a, logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_exp(int r);
        e_ha = T_HA[r]; e_hf = T_HF[r]; e_hb = T_HB[r]; e_hw = T_HW[r];
        e_va = T_VA[r]; e_vf = T_VF[r]; e_vb = T_VB[r]; e_vw = T_VW[r];
        e_pv = T_PV[r]; e_ph = T_PH[r]; e_en = T_EN[r]; e_rp = T_RP[r];
        e_hd = T_HD[r]; e_il = T_IL[r];
    endtask

    task automatic program_row(int r);   // R1 address map and packing
        wr_reg(3'd0, (32'(T_EN[r]) << 31) | (32'(T_HD[r]) << 30) | (32'(T_IL[r]) << 4) | 32'(T_RP[r]));
        wr_reg(3'd1, pk(T_VA[r], T_HA[r]));
        wr_reg(3'd2, pk(T_VB[r], T_HB[r]));
        wr_reg(3'd3, pk(T_VF[r], T_HF[r]));
        wr_reg(3'd4, pk(T_VW[r], T_HW[r]));
        wr_reg(3'd5, (32'(T_PV[r]) << 1) | 32'(T_PH[r]));
    endtask

    task automatic wait_origin();
        while (!(h_pos_o == 0 && v_pos_o == 0)) @(negedge clk);
    endtask

    task automatic wait_new_frame();
        wait_origin();
        @(negedge clk);
        wait_origin();
    endtask

    // At entry the outputs show (0,0); at exit they show the next frame's (0,0).
    task automatic check_frame();
        int ht = e_ha + e_hf + e_hb;
        int vt = e_va + e_vf + e_vb;
        chk("R9", "hdmi_mode", int'(hdmi_mode_o), e_hd);
        chk("R9", "interlace", int'(interlace_o), e_il);
        for (int v = 0; v < vt; v++) begin
            for (int h = 0; h < ht; h++) begin
                bit ha_on = (h >= e_ha + e_hf) && (h < e_ha + e_hf + e_hw);
                bit va_on = (v >= e_va + e_vf) && (v < e_va + e_vf + e_vw);
                int hs_e = (e_en != 0) ? (e_ph != 0 ? int'(ha_on) : int'(!ha_on)) : int'(e_ph == 0);
                int vs_e = (e_en != 0) ? (e_pv != 0 ? int'(va_on) : int'(!va_on)) : int'(e_pv == 0);
                int de_e = int'((e_en != 0) && h < e_ha && v < e_va);
                chk("R2", "h_pos", int'(h_pos_o), h);
                chk("R2", "v_pos", int'(v_pos_o), v);
                chk(e_en != 0 ? "R3" : "R6", "de", int'(de_o), de_e);
                chk(e_en != 0 ? "R4 R5" : "R6", "hsync", int'(hsync_o), hs_e);
                chk(e_en != 0 ? "R4 R5" : "R6", "vsync", int'(vsync_o), vs_e);
                chk("R8", "src_px", int'(src_px_o), e_rp != 0 ? h / 2 : h);
                @(negedge clk);
            end
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        repeat (4) @(negedge clk);
        // R10 reset state
        chk("R10", "de reset", int'(de_o), 0);
        chk("R10", "hsync reset", int'(hsync_o), 1);
        chk("R10", "vsync reset", int'(vsync_o), 1);
        chk("R10", "h_pos reset", int'(h_pos_o), 0);
        chk("R10", "v_pos reset", int'(v_pos_o), 0);
        rst_n = 1'b1;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk("R10", "h_pos step", int'(h_pos_o), (k == 3) ? 0 : k);
            chk("R10", "v_pos step", int'(v_pos_o), (k == 3) ? 1 : 0);
            chk("R10", "hsync idle", int'(hsync_o), 1);
            chk("R10", "de idle", int'(de_o), 0);
        end

        // Table walk: program, let the shadow reload, check a full frame.
        for (int r = 0; r < NROW; r++) begin
            program_row(r);
            wait_new_frame();
            set_exp(r);
            check_frame();
        end

        // R7: mid-frame write leaves the current frame untouched.
        program_row(0);
        wait_new_frame();
        set_exp(0);
        fork
            wr_reg(3'd1, pk(4, 4));
            check_frame();
        join
        e_ha = 4;
        check_frame();   // R7 new geometry from next frame

        // R7: write coinciding with the frame boundary applies one frame later.
        while (!(h_pos_o == 18'(e_ha + e_hf + e_hb - 2) &&
                 v_pos_o == 18'(e_va + e_vf + e_vb - 1))) @(negedge clk);
        wr_reg(3'd1, pk(4, 8));
        @(negedge clk);
        chk("R7", "boundary origin h", int'(h_pos_o), 0);
        check_frame();   // still HA 4
        e_ha = 8;
        check_frame();   // now HA 8

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule